// File: doc/BRIEF.md
# Lane Parity Guard with Error Injection

This block protects a 64-bit data bus with one even-parity bit per 16-bit lane, so every bus word carries four check bits. On the send side it only computes the four parity bits for an outgoing word. On the read-return side it recomputes lane parity over the incoming word and compares it against the parity bits that arrived with it. It flags every lane that disagrees and raises a single summary error bit.

Two settings sit in an 8-bit configuration register that is written through a one-cycle write strobe and can be read back at any time. A 4-bit injection mask is XORed onto the recomputed parity before the compare. Test software uses it to force chosen lanes to miscompare on good data. A detection-enable bit gates the error outputs. Both settings are clear after reset, so checking is off and nothing is injected until software writes the register.

Top module: `dbpar_guard`

## Requirements
- R1: `tx_par[i]` is, in the same cycle, the XOR of `tx_data[16i+15:16i]` (even parity) for lanes i = 0..3.
- R2: A cycle with `cfg_we` high loads `cfg_wdata[3:0]` as the injection mask and `cfg_wdata[4]` as the detection enable. Both take effect from the next cycle. `cfg_rdata` returns `{3'b000, enable, mask}`.
- R3: While `rst_n` is low at a clock edge, the mask and the enable clear to 0 and `err_lane` and `err_any` go to 0 at that edge.
- R4: With detection enabled, a beat with `rd_valid` high produces `err_lane[i]` = (parity of `rd_data[16i+15:16i]` XOR mask[i]) XOR `rd_par[i]` in the following cycle.
- R5: `err_any` is high in exactly the cycles where `err_lane` is non-zero. Each flagged beat raises it for one cycle.
- R6: With detection disabled, `err_lane` and `err_any` stay 0 regardless of mask, data or received parity.
- R7: With a zero mask and correct received parity, no error is reported.
- R8: A cycle with `rd_valid` low produces no error in the following cycle, even if `rd_data` and `rd_par` disagree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Write data: [3:0] mask, [4] enable |
| cfg_rdata | output | 8 | Configuration readback |
| tx_data | input | 64 | Outgoing word |
| tx_par | output | 4 | Lane parity of the outgoing word |
| rd_valid | input | 1 | Read-return beat valid |
| rd_data | input | 64 | Read-return word |
| rd_par | input | 4 | Parity bits received with the word |
| err_lane | output | 4 | Per-lane mismatch, one cycle after the beat |
| err_any | output | 1 | Any lane mismatched |

## Verification
The hardest state to reach is a miscompare on a lane whose data and received parity are consistent, because that only happens through the mask. The stimulus writes non-zero masks next to both correct and deliberately wrong received parity, so a mask bit and a real error on the same lane cancel. The bench also drives bad parity while detection is off and while `rd_valid` is low. It then issues a reset in mid-run with a non-zero mask loaded, to show that the settings really clear.

// File: rtl/dbpar_pkg.sv
// Package: shared constants for the lane parity guard.
// Assumes the configuration register is at least one bit wider than the lane count.
package dbpar_pkg;
    localparam int DEF_BUS_W  = 64;
    localparam int DEF_LANE_W = 16;
    localparam int DEF_CFG_W  = 8;
endpackage

// File: rtl/dbpar_lane_parity.sv
// Module: dbpar_lane_parity
// Computes one even-parity bit per LANE_W-bit lane of a BUS_W-bit word.
// Assumes BUS_W is a whole multiple of LANE_W. Purely combinational.
module dbpar_lane_parity #(
    parameter int BUS_W  = dbpar_pkg::DEF_BUS_W,
    parameter int LANE_W = dbpar_pkg::DEF_LANE_W,
    localparam int LANES = BUS_W / LANE_W
) (
    input  logic [BUS_W-1:0] word,
    output logic [LANES-1:0] par
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // reduce one lane to its even-parity bit
        always_comb par[g] = ^word[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/dbpar_cfg.sv
// Module: dbpar_cfg
// Holds the injection mask (low LANES bits) and the detection enable (bit LANES).
// Assumes CFG_W > LANES. Writes land at the clock edge of the strobe cycle.
module dbpar_cfg #(
    parameter int LANES = 4,
    parameter int CFG_W = dbpar_pkg::DEF_CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [LANES-1:0] mask,
    output logic             en,
    output logic [CFG_W-1:0] cfg_rdata
);
    localparam int EN_BIT = LANES;

    // load the settings on a write, clear them on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
            en   <= 1'b0;
        end else if (cfg_we) begin
            mask <= cfg_wdata[LANES-1:0];
            en   <= cfg_wdata[EN_BIT];
        end
    end

    // assemble the readback word
    always_comb begin
        cfg_rdata              = '0;
        cfg_rdata[LANES-1:0]   = mask;
        cfg_rdata[EN_BIT]      = en;
    end

    // R2
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (mask == $past(cfg_wdata[LANES-1:0]) && en == $past(cfg_wdata[EN_BIT])));

    // R3
    cfg_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (mask == '0 && !en));
endmodule

// File: rtl/dbpar_cmp.sv
// Module: dbpar_cmp
// Compares masked recomputed parity with received parity and registers the result.
// Assumes calc_par is the plain lane parity of the beat presented with rd_valid.
module dbpar_cmp #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_valid,
    input  logic             en,
    input  logic [LANES-1:0] mask,
    input  logic [LANES-1:0] calc_par,
    input  logic [LANES-1:0] rd_par,
    output logic [LANES-1:0] err_lane,
    output logic             err_any
);
    logic [LANES-1:0] miss;

    // lanes that disagree after injection, gated by valid and enable
    always_comb miss = ((calc_par ^ mask) ^ rd_par) & {LANES{rd_valid & en}};

    // register the per-lane flags and the summary pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_lane <= '0;
            err_any  <= 1'b0;
        end else begin
            err_lane <= miss;
            err_any  <= |miss;
        end
    end

    // R5
    any_matches_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_any == (err_lane != '0));

    // R6
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !err_any);

    // R8
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> (err_lane == '0));

    // R7
    clean_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && mask == '0 && rd_par == calc_par) |=> (err_lane == '0));
endmodule

// File: rtl/dbpar_guard.sv
// Module: dbpar_guard (top)
// Lane parity generator for outgoing words and checker with error injection
// for read-return words. Assumes one beat per cycle on the return path.
module dbpar_guard #(
    parameter int BUS_W  = dbpar_pkg::DEF_BUS_W,
    parameter int LANE_W = dbpar_pkg::DEF_LANE_W,
    parameter int CFG_W  = dbpar_pkg::DEF_CFG_W,
    localparam int LANES = BUS_W / LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic [BUS_W-1:0] tx_data,
    output logic [LANES-1:0] tx_par,
    input  logic             rd_valid,
    input  logic [BUS_W-1:0] rd_data,
    input  logic [LANES-1:0] rd_par,
    output logic [LANES-1:0] err_lane,
    output logic             err_any
);
    logic [LANES-1:0] mask;
    logic             en;
    logic [LANES-1:0] rd_calc;

    dbpar_cfg #(.LANES(LANES), .CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .mask(mask), .en(en), .cfg_rdata(cfg_rdata)
    );

    dbpar_lane_parity #(.BUS_W(BUS_W), .LANE_W(LANE_W)) u_tx_par (
        .word(tx_data), .par(tx_par)
    );

    dbpar_lane_parity #(.BUS_W(BUS_W), .LANE_W(LANE_W)) u_rd_par (
        .word(rd_data), .par(rd_calc)
    );

    dbpar_cmp #(.LANES(LANES)) u_cmp (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .en(en), .mask(mask),
        .calc_par(rd_calc), .rd_par(rd_par), .err_lane(err_lane), .err_any(err_any)
    );

    // R3
    err_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (err_lane == '0 && !err_any));

    // R4
    lane_flag_needs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_lane != '0) |-> ($past(rd_valid) && $past(en)));
endmodule

// File: tb/dbpar_guard_test.sv
`timescale 1ns/1ps
module dbpar_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [63:0] tx_data = '0;
    logic [3:0]  tx_par;
    logic        rd_valid = 1'b0;
    logic [63:0] rd_data = '0;
    logic [3:0]  rd_par = '0;
    logic [3:0]  err_lane;
    logic        err_any;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dbpar_guard uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tx_data(tx_data), .tx_par(tx_par),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_par(rd_par),
        .err_lane(err_lane), .err_any(err_any)
    );

    // table row: [72] enable, [71:68] mask, [67:64] received parity, [63:0] data
    localparam logic [72:0] VEC [8] = '{
        {1'b1, 4'h0, 4'h0, 64'h0000_0000_0000_0000},
        {1'b1, 4'h0, 4'hF, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b1, 4'h5, 4'h0, 64'h0000_0000_0000_0000},
        {1'b1, 4'h0, 4'h1, 64'h0000_0000_0000_0001},
        {1'b1, 4'hA, 4'h3, 64'h8000_0001_0001_0001},
        {1'b0, 4'hF, 4'h0, 64'h1234_5678_9ABC_DEF1},
        {1'b1, 4'h0, 4'h9, 64'h0123_4567_89AB_CDEF},
        {1'b1, 4'hF, 4'h0, 64'hDEAD_BEEF_0BAD_F00D}
    };

    function automatic logic [3:0] lanepar(input logic [63:0] d);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = ^d[16*i +: 16];
        return p;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic en, input logic [3:0] m);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = {3'b000, en, m};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drive one beat at a negedge; results are sampled at the following negedge
    task automatic beat(input logic v, input logic [63:0] d, input logic [3:0] p,
                        output logic [3:0] lanes, output logic any);
        rd_valid = v;
        rd_data = d;
        rd_par = p;
        @(negedge clk);
        lanes = err_lane;
        any = err_any;
        rd_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [3:0] lanes;
        logic any;
        repeat (3) @(negedge clk);
        // R3: reset state
        chk("R3 cfg after reset", cfg_rdata, 8'h00);
        chk("R3 err_lane after reset", err_lane, 4'h0);
        chk("R3 err_any after reset", err_any, 1'b0);
        rst_n = 1'b1;

        // vector table walk: R1, R2, R4, R5, R6, R7
        for (int k = 0; k < 8; k++) begin
            logic [3:0] exp_l;
            write_cfg(VEC[k][72], VEC[k][71:68]);
            chk("R2 cfg readback", cfg_rdata, {3'b000, VEC[k][72], VEC[k][71:68]});
            tx_data = VEC[k][63:0];
            #1;
            chk("R1 tx lane parity", tx_par, lanepar(VEC[k][63:0]));
            exp_l = (lanepar(VEC[k][63:0]) ^ VEC[k][71:68] ^ VEC[k][67:64]) & {4{VEC[k][72]}};
            @(negedge clk);
            beat(1'b1, VEC[k][63:0], VEC[k][67:64], lanes, any);
            chk("R4 err_lane vector", lanes, exp_l);
            chk("R5 err_any vector", any, |exp_l);
            @(negedge clk);
            chk("R5 err_any single pulse", err_any, 1'b0);
        end

        // R7: zero mask, correct parity on a busy pattern
        write_cfg(1'b1, 4'h0);
        beat(1'b1, 64'hA5A5_0F0F_3C3C_7E81, lanepar(64'hA5A5_0F0F_3C3C_7E81), lanes, any);
        chk("R7 clean beat no error", {any, lanes}, 5'h00);

        // R6: detection off, wrong parity plus mask
        write_cfg(1'b0, 4'hC);
        beat(1'b1, 64'h0, 4'h3, lanes, any);
        chk("R6 disabled err_lane", lanes, 4'h0);
        chk("R6 disabled err_any", any, 1'b0);

        // R8: enabled but no valid beat, bad parity on the bus
        write_cfg(1'b1, 4'h0);
        beat(1'b0, 64'h0, 4'hF, lanes, any);
        chk("R8 idle err_lane", lanes, 4'h0);
        chk("R8 idle err_any", any, 1'b0);

        // R4: mask cancels a real error on the same lane
        write_cfg(1'b1, 4'h2);
        beat(1'b1, 64'h0, 4'h2, lanes, any);
        chk("R4 mask cancels real error", lanes, 4'h0);

        // R4/R5: back-to-back flagged beats
        write_cfg(1'b1, 4'h0);
        rd_valid = 1'b1; rd_data = 64'h0; rd_par = 4'h1;
        @(negedge clk);
        rd_par = 4'h8;
        chk("R4 first of two beats", err_lane, 4'h1);
        @(negedge clk);
        rd_valid = 1'b0;
        chk("R4 second of two beats", err_lane, 4'h8);
        chk("R5 err_any second beat", err_any, 1'b1);

        // R3: mid-run reset clears loaded settings
        write_cfg(1'b1, 4'h9);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R3 mid-run reset cfg", cfg_rdata, 8'h00);
        rst_n = 1'b1;
        beat(1'b1, 64'h0, 4'hF, lanes, any);
        chk("R3 detection off after reset", {any, lanes}, 5'h00);

        finish_run();
    end
endmodule